// File: doc/BRIEF.md
# Accumulator-Style 8-bit Arithmetic/Logic Unit

This block is the data-path core of a small accumulator-based processor. It keeps the accumulator, two index registers (X and Y) and the 8-bit processor status byte. On every rising clock edge where the enable input is high, it takes one opcode byte and one operand byte. It updates whichever registers and flags that opcode affects. The surrounding sequencer fetches instructions, forms addresses and reads or writes memory. The operand byte is whatever that sequencer fetched: an immediate value, a memory byte, or a status byte pulled from the stack.

Read-modify-write operations on memory (increment, decrement, shift and rotate of the operand) return their result through the accumulator output register, where the sequencer picks it up for write-back. The X-to-stack transfer also routes X through that register, so the stack pointer held outside the block can capture it. Opcodes outside the supported set leave all state unchanged. These include opcodes that only move data out of the block, and those that only alter control flow.

Decoding is a single combinational step from opcode byte to an operation class (`op_kind_e`). The class selects one arm of the execute logic. The block holds no multi-cycle state: each enabled cycle is a complete transition from the current register set to the next one.

Top module: `accu_alu`

## Requirements
- R1: After an active-low reset, the accumulator, X and Y read 0x00 and the status reads 0x22. Status bits are N=7, V=6, constant one=5, B=4, D=3, I=2, Z=1, C=0, and bit 5 always reads 1.
- R2: State changes only on a rising clock edge with `en` high. With `en` low, all four outputs hold whatever opcode and operand are applied.
- R3: The load opcodes 0xA9 (A), 0xA2 (X) and 0xA0 (Y) copy the operand into the named register. Z is set when that value is zero, and N takes its bit 7.
- R4: 0x69 with D=0 sets A to A+operand+C. C takes the carry out of bit 7. V is set when both addends have the same sign and the result's sign differs. Z and N follow the result.
- R5: 0x69 with D=1 performs a decimal add.
  - Low nibble: form A[3:0]+op[3:0]+C, and add 6 if that sum exceeds 9.
  - High nibble: form A[7:4]+op[7:4]+(carry from the corrected low nibble), and add 6 if that sum exceeds 9.
  - C is set when the corrected high sum exceeds 15.
  - V is taken from the binary sum; Z and N come from the corrected result.
- R6: 0xE9 sets A to A−operand−(1−C) in binary whatever D is. C is 1 when no borrow occurs. V is set when A and the operand differ in sign and the result's sign differs from A. Z and N follow the result.
- R7: 0x29 (AND), 0x09 (OR) and 0x49 (XOR) combine A with the operand into A, and set Z and N from the result.
- R8: Shifts and rotates.
  - 0x0E shifts the operand left into A, with bit 7 going to C.
  - 0x2E rotates the operand left through C.
  - 0x6E rotates it right through C (old C into bit 7, bit 0 into C).
  - 0x0A shifts A itself left.
  - All four set Z and N from the result.
- R9: Compares 0xC9 (A), 0xE0 (X) and 0xC0 (Y) set C when the register is greater than or equal to the operand, and set Z and N from the 8-bit difference. No data register changes.
- R10: 0xE6 writes operand+1 and 0xC6 writes operand−1 into A. 0xE8/0xC8 increment X/Y and 0xCA/0x88 decrement X/Y, all modulo 256. All of them set Z and N from the written value.
- R11: 0x24 sets Z when (A AND operand) is zero, copies operand bit 7 to N and bit 6 to V, and leaves A unchanged.
- R12: Transfers 0xAA (A→X), 0xA8 (A→Y), 0x8A (X→A), 0x98 (Y→A) and 0xBA (operand→X) set Z and N from the destination. 0x9A copies X into A and leaves every flag unchanged.
- R13: Status opcodes.
  - 0x28 and 0x40 load the status from the operand, with bit 5 forced to 1.
  - 0x00 sets B.
  - 0x38/0x18 set/clear C, 0xF8/0xD8 set/clear D, 0x78/0x58 set/clear I, and 0xB8 clears V.
- R14: Every other opcode (for example 0x8D, 0x48, 0x08, 0x4C, 0x20, 0x60, 0xEA, 0xF0, 0x02) changes no register and no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Executes the presented opcode on this edge when high |
| opcode | input | 8 | Operation byte |
| operand | input | 8 | Data byte fetched by the sequencer |
| acc_q | output | 8 | Accumulator (also carries read-modify-write results) |
| x_q | output | 8 | X index register |
| y_q | output | 8 | Y index register |
| status_q | output | 8 | Processor status byte |

## Verification
The following properties are checked on every clock by the bound checker:
- Bit 5 of the status is constant.
- All state holds while `en` is low.
- Loads and X increments produce the operand or successor value.
- A compare never disturbs a data register.
- The bit test copies operand bits 7 and 6 into N and V.
- A status pull mirrors the operand.
- A binary add gives the 9-bit sum.
- A no-op changes nothing.

Decimal correction, subtract borrow and overflow, and rotate carry chaining depend on earlier flag history. So do transfer sequences and the full unsupported-opcode space. Those are shown only by the bench: directed corner cases, plus a long seeded random opcode/operand stream compared against a reference model.

// File: rtl/accu_alu_pkg.sv
package accu_alu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;

    // status bit positions (fixed by the surrounding sequencer)
    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_I = 2;
    localparam int F_D = 3;
    localparam int F_B = 4;
    localparam int F_1 = 5;
    localparam int F_V = 6;
    localparam int F_N = 7;

    localparam logic [DATA_W-1:0] ST_RESET = 8'h22;
    localparam logic [DATA_W-1:0] ST_ONE   = 8'h20;

    // opcode byte values
    localparam logic [7:0] OPC_LD_A   = 8'hA9;
    localparam logic [7:0] OPC_LD_X   = 8'hA2;
    localparam logic [7:0] OPC_LD_Y   = 8'hA0;
    localparam logic [7:0] OPC_ADDC   = 8'h69;
    localparam logic [7:0] OPC_SUBC   = 8'hE9;
    localparam logic [7:0] OPC_AND    = 8'h29;
    localparam logic [7:0] OPC_OR     = 8'h09;
    localparam logic [7:0] OPC_XOR    = 8'h49;
    localparam logic [7:0] OPC_SHL_M  = 8'h0E;
    localparam logic [7:0] OPC_SHL_A  = 8'h0A;
    localparam logic [7:0] OPC_ROTL_M = 8'h2E;
    localparam logic [7:0] OPC_ROTR_M = 8'h6E;
    localparam logic [7:0] OPC_CMP_A  = 8'hC9;
    localparam logic [7:0] OPC_CMP_X  = 8'hE0;
    localparam logic [7:0] OPC_CMP_Y  = 8'hC0;
    localparam logic [7:0] OPC_INC_M  = 8'hE6;
    localparam logic [7:0] OPC_DEC_M  = 8'hC6;
    localparam logic [7:0] OPC_INC_X  = 8'hE8;
    localparam logic [7:0] OPC_INC_Y  = 8'hC8;
    localparam logic [7:0] OPC_DEC_X  = 8'hCA;
    localparam logic [7:0] OPC_DEC_Y  = 8'h88;
    localparam logic [7:0] OPC_BITT   = 8'h24;
    localparam logic [7:0] OPC_PULL_S = 8'h28;
    localparam logic [7:0] OPC_RET_IR = 8'h40;
    localparam logic [7:0] OPC_BREAK  = 8'h00;
    localparam logic [7:0] OPC_SET_C  = 8'h38;
    localparam logic [7:0] OPC_CLR_C  = 8'h18;
    localparam logic [7:0] OPC_SET_D  = 8'hF8;
    localparam logic [7:0] OPC_CLR_D  = 8'hD8;
    localparam logic [7:0] OPC_SET_I  = 8'h78;
    localparam logic [7:0] OPC_CLR_I  = 8'h58;
    localparam logic [7:0] OPC_CLR_V  = 8'hB8;
    localparam logic [7:0] OPC_A2X    = 8'hAA;
    localparam logic [7:0] OPC_A2Y    = 8'hA8;
    localparam logic [7:0] OPC_X2A    = 8'h8A;
    localparam logic [7:0] OPC_Y2A    = 8'h98;
    localparam logic [7:0] OPC_S2X    = 8'hBA;
    localparam logic [7:0] OPC_X2S    = 8'h9A;
    localparam logic [7:0] OPC_IDLE   = 8'hEA;

    typedef enum logic [5:0] {
        K_NONE, K_LDA, K_LDX, K_LDY, K_ADC, K_SBC, K_AND, K_ORA, K_EOR,
        K_SHLM, K_SHLA, K_ROLM, K_RORM, K_CMPA, K_CMPX, K_CMPY,
        K_INCM, K_DECM, K_INX, K_INY, K_DEX, K_DEY, K_BIT, K_PULL,
        K_BRK, K_SEC, K_CLC, K_SED, K_CLD, K_SEI, K_CLI, K_CLV,
        K_TAX, K_TAY, K_TXA, K_TYA, K_TSX, K_TXS
    } op_kind_e;

endpackage

// File: rtl/accu_alu_decode.sv
module accu_alu_decode
    import accu_alu_pkg::*;
(
    input  logic [7:0] opcode,
    output op_kind_e   kind
);
    always_comb begin
        unique case (opcode)
            OPC_LD_A:   kind = K_LDA;
            OPC_LD_X:   kind = K_LDX;
            OPC_LD_Y:   kind = K_LDY;
            OPC_ADDC:   kind = K_ADC;
            OPC_SUBC:   kind = K_SBC;
            OPC_AND:    kind = K_AND;
            OPC_OR:     kind = K_ORA;
            OPC_XOR:    kind = K_EOR;
            OPC_SHL_M:  kind = K_SHLM;
            OPC_SHL_A:  kind = K_SHLA;
            OPC_ROTL_M: kind = K_ROLM;
            OPC_ROTR_M: kind = K_RORM;
            OPC_CMP_A:  kind = K_CMPA;
            OPC_CMP_X:  kind = K_CMPX;
            OPC_CMP_Y:  kind = K_CMPY;
            OPC_INC_M:  kind = K_INCM;
            OPC_DEC_M:  kind = K_DECM;
            OPC_INC_X:  kind = K_INX;
            OPC_INC_Y:  kind = K_INY;
            OPC_DEC_X:  kind = K_DEX;
            OPC_DEC_Y:  kind = K_DEY;
            OPC_BITT:   kind = K_BIT;
            OPC_PULL_S: kind = K_PULL;
            OPC_RET_IR: kind = K_PULL;
            OPC_BREAK:  kind = K_BRK;
            OPC_SET_C:  kind = K_SEC;
            OPC_CLR_C:  kind = K_CLC;
            OPC_SET_D:  kind = K_SED;
            OPC_CLR_D:  kind = K_CLD;
            OPC_SET_I:  kind = K_SEI;
            OPC_CLR_I:  kind = K_CLI;
            OPC_CLR_V:  kind = K_CLV;
            OPC_A2X:    kind = K_TAX;
            OPC_A2Y:    kind = K_TAY;
            OPC_X2A:    kind = K_TXA;
            OPC_Y2A:    kind = K_TYA;
            OPC_S2X:    kind = K_TSX;
            OPC_X2S:    kind = K_TXS;
            default:    kind = K_NONE;  // R14: all else is a no-op
        endcase
    end
endmodule

// File: rtl/accu_alu_adder.sv
module accu_alu_adder
    import accu_alu_pkg::*;
#(
    parameter bit DECIMAL_EN = 1'b1
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    input  logic              dec_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              ovf_o
);
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   bin;

    // subtract as A + ~B + C: carry out means no borrow
    assign b_eff  = sub_i ? ~b_i : b_i;
    assign bin    = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_i};
    assign ovf_o  = (a_i[DATA_W-1] == b_eff[DATA_W-1]) && (bin[DATA_W-1] != a_i[DATA_W-1]);

    generate
        if (DECIMAL_EN) begin : g_bcd
            logic [NIB_W:0]   lo_raw, lo_fix;
            logic [NIB_W+1:0] hi_raw, hi_fix;
            always_comb begin
                lo_raw = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]}
                       + {{NIB_W{1'b0}}, cin_i};
                lo_fix = (lo_raw > 5'd9) ? lo_raw + 5'd6 : lo_raw;
                hi_raw = {2'b00, a_i[DATA_W-1:NIB_W]} + {2'b00, b_i[DATA_W-1:NIB_W]}
                       + {{(NIB_W+1){1'b0}}, lo_fix[NIB_W]};
                hi_fix = (hi_raw > 6'd9) ? hi_raw + 6'd6 : hi_raw;
            end
            always_comb begin
                if (dec_i && !sub_i) begin
                    sum_o  = {hi_fix[NIB_W-1:0], lo_fix[NIB_W-1:0]};
                    cout_o = (hi_fix > 6'd15);
                end else begin
                    sum_o  = bin[DATA_W-1:0];
                    cout_o = bin[DATA_W];
                end
            end
        end else begin : g_bin
            logic unused_dec;
            assign unused_dec = dec_i;
            assign sum_o      = bin[DATA_W-1:0];
            assign cout_o     = bin[DATA_W];
        end
    endgenerate
endmodule

// File: rtl/accu_alu_exec.sv
module accu_alu_exec
    import accu_alu_pkg::*;
#(
    parameter bit DECIMAL_EN = 1'b1
) (
    input  op_kind_e          kind,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic [DATA_W-1:0] p_i,
    output logic              wr_a,
    output logic              wr_x,
    output logic              wr_y,
    output logic [DATA_W-1:0] val,
    output logic [DATA_W-1:0] p_o
);
    logic [DATA_W-1:0] add_sum;
    logic              add_c, add_v;

    accu_alu_adder #(.DECIMAL_EN(DECIMAL_EN)) u_add (
        .a_i   (a_i),
        .b_i   (operand),
        .cin_i (p_i[F_C]),
        .sub_i (kind == K_SBC),
        .dec_i (p_i[F_D]),
        .sum_o (add_sum),
        .cout_o(add_c),
        .ovf_o (add_v)
    );

    function automatic logic [DATA_W-1:0] with_zn(input logic [DATA_W-1:0] p,
                                                  input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        r      = p;
        r[F_Z] = (v == '0);
        r[F_N] = v[DATA_W-1];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] cmp_flags(input logic [DATA_W-1:0] p,
                                                    input logic [DATA_W-1:0] r,
                                                    input logic [DATA_W-1:0] m);
        logic [DATA_W-1:0] q;
        q      = with_zn(p, r - m);
        q[F_C] = (r >= m);
        return q;
    endfunction

    always_comb begin
        wr_a = 1'b0;
        wr_x = 1'b0;
        wr_y = 1'b0;
        val  = a_i;
        p_o  = p_i;
        unique case (kind)
            K_LDA:  begin wr_a = 1'b1; val = operand; end
            K_LDX:  begin wr_x = 1'b1; val = operand; end
            K_LDY:  begin wr_y = 1'b1; val = operand; end
            K_ADC, K_SBC: begin
                wr_a = 1'b1; val = add_sum;
            end
            K_AND:  begin wr_a = 1'b1; val = a_i & operand; end
            K_ORA:  begin wr_a = 1'b1; val = a_i | operand; end
            K_EOR:  begin wr_a = 1'b1; val = a_i ^ operand; end
            K_SHLM: begin wr_a = 1'b1; val = {operand[DATA_W-2:0], 1'b0}; end
            K_SHLA: begin wr_a = 1'b1; val = {a_i[DATA_W-2:0], 1'b0}; end
            K_ROLM: begin wr_a = 1'b1; val = {operand[DATA_W-2:0], p_i[F_C]}; end
            K_RORM: begin wr_a = 1'b1; val = {p_i[F_C], operand[DATA_W-1:1]}; end
            K_INCM: begin wr_a = 1'b1; val = operand + 1'b1; end
            K_DECM: begin wr_a = 1'b1; val = operand - 1'b1; end
            K_INX:  begin wr_x = 1'b1; val = x_i + 1'b1; end
            K_INY:  begin wr_y = 1'b1; val = y_i + 1'b1; end
            K_DEX:  begin wr_x = 1'b1; val = x_i - 1'b1; end
            K_DEY:  begin wr_y = 1'b1; val = y_i - 1'b1; end
            K_TAX:  begin wr_x = 1'b1; val = a_i; end
            K_TAY:  begin wr_y = 1'b1; val = a_i; end
            K_TXA:  begin wr_a = 1'b1; val = x_i; end
            K_TYA:  begin wr_a = 1'b1; val = y_i; end
            K_TSX:  begin wr_x = 1'b1; val = operand; end
            K_TXS:  begin wr_a = 1'b1; val = x_i; end
            default: ;
        endcase

        // flag rules per operation class
        unique case (kind)
            K_LDA, K_LDX, K_LDY, K_AND, K_ORA, K_EOR, K_INCM, K_DECM,
            K_INX, K_INY, K_DEX, K_DEY, K_TAX, K_TAY, K_TXA, K_TYA, K_TSX:
                p_o = with_zn(p_i, val);
            K_ADC, K_SBC: begin
                p_o      = with_zn(p_i, add_sum);
                p_o[F_C] = add_c;
                p_o[F_V] = add_v;
            end
            K_SHLM, K_ROLM: begin
                p_o      = with_zn(p_i, val);
                p_o[F_C] = operand[DATA_W-1];
            end
            K_SHLA: begin
                p_o      = with_zn(p_i, val);
                p_o[F_C] = a_i[DATA_W-1];
            end
            K_RORM: begin
                p_o      = with_zn(p_i, val);
                p_o[F_C] = operand[0];
            end
            K_CMPA: p_o = cmp_flags(p_i, a_i, operand);
            K_CMPX: p_o = cmp_flags(p_i, x_i, operand);
            K_CMPY: p_o = cmp_flags(p_i, y_i, operand);
            K_BIT: begin
                p_o      = p_i;
                p_o[F_Z] = ((a_i & operand) == '0);
                p_o[F_V] = operand[F_V];
                p_o[F_N] = operand[F_N];
            end
            K_PULL: p_o = operand | ST_ONE;
            K_BRK:  p_o[F_B] = 1'b1;
            K_SEC:  p_o[F_C] = 1'b1;
            K_CLC:  p_o[F_C] = 1'b0;
            K_SED:  p_o[F_D] = 1'b1;
            K_CLD:  p_o[F_D] = 1'b0;
            K_SEI:  p_o[F_I] = 1'b1;
            K_CLI:  p_o[F_I] = 1'b0;
            K_CLV:  p_o[F_V] = 1'b0;
            default: ;
        endcase
    end
endmodule

// File: rtl/accu_alu.sv
module accu_alu
    import accu_alu_pkg::*;
#(
    parameter bit DECIMAL_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc_q,
    output logic [DATA_W-1:0] x_q,
    output logic [DATA_W-1:0] y_q,
    output logic [DATA_W-1:0] status_q
);
    op_kind_e          kind;
    logic              wr_a, wr_x, wr_y;
    logic [DATA_W-1:0] val, p_nxt;
    logic [DATA_W-1:0] a_r, x_r, y_r, p_r;

    accu_alu_decode u_dec (
        .opcode(opcode),
        .kind  (kind)
    );

    accu_alu_exec #(.DECIMAL_EN(DECIMAL_EN)) u_exe (
        .kind   (kind),
        .operand(operand),
        .a_i    (a_r),
        .x_i    (x_r),
        .y_i    (y_r),
        .p_i    (p_r),
        .wr_a   (wr_a),
        .wr_x   (wr_x),
        .wr_y   (wr_y),
        .val    (val),
        .p_o    (p_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_r <= '0;
            x_r <= '0;
            y_r <= '0;
            p_r <= ST_RESET;
        end else if (en) begin
            if (wr_a) a_r <= val;
            if (wr_x) x_r <= val;
            if (wr_y) y_r <= val;
            p_r <= p_nxt;
        end
    end

    assign acc_q    = a_r;
    assign x_q      = x_r;
    assign y_q      = y_r;
    assign status_q = p_r;
endmodule

// File: rtl/accu_alu_chk.sv
module accu_alu_chk
    import accu_alu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [7:0]        opcode,
    input logic [DATA_W-1:0] operand,
    input logic [DATA_W-1:0] acc_q,
    input logic [DATA_W-1:0] x_q,
    input logic [DATA_W-1:0] y_q,
    input logic [DATA_W-1:0] status_q
);
    AST_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[F_1]); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(acc_q) && $stable(x_q) && $stable(y_q) && $stable(status_q))); // R2

    AST_LOAD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (en && opcode == OPC_LD_A) |=>
        (acc_q == $past(operand) && status_q[F_Z] == ($past(operand) == '0))); // R3

    AST_ADD_BIN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && opcode == OPC_ADDC && !status_q[F_D]) |=>
        ({status_q[F_C], acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(operand)}
                                    + {{DATA_W{1'b0}}, $past(status_q[F_C])}))); // R4

    AST_INX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && opcode == OPC_INC_X) |=> (x_q == $past(x_q) + 1'b1)); // R10

    AST_CMP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (opcode == OPC_CMP_A || opcode == OPC_CMP_X || opcode == OPC_CMP_Y)) |=>
        ($stable(acc_q) && $stable(x_q) && $stable(y_q))); // R9

    AST_BIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (en && opcode == OPC_BITT) |=>
        (status_q[F_N] == $past(operand[F_N]) && status_q[F_V] == $past(operand[F_V])
         && $stable(acc_q))); // R11

    AST_PULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && opcode == OPC_PULL_S) |=> (status_q == ($past(operand) | ST_ONE))); // R13

    AST_IDLE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && opcode == OPC_IDLE) |=>
        ($stable(acc_q) && $stable(x_q) && $stable(y_q) && $stable(status_q))); // R14
endmodule

bind accu_alu accu_alu_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .opcode  (opcode),
    .operand (operand),
    .acc_q   (acc_q),
    .x_q     (x_q),
    .y_q     (y_q),
    .status_q(status_q)
);

// File: tb/accu_alu_tb.sv
module accu_alu_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] opcode = 8'hEA;
    logic [7:0] operand = 8'h00;
    logic [7:0] acc_q, x_q, y_q, status_q;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [7:0] ma, mx, my, mp;

    localparam logic [7:0] SUPPORTED [0:37] = '{
        8'hA9, 8'hA2, 8'hA0, 8'h69, 8'hE9, 8'h29, 8'h09, 8'h49, 8'h0E, 8'h0A,
        8'h2E, 8'h6E, 8'hC9, 8'hE0, 8'hC0, 8'hE6, 8'hC6, 8'hE8, 8'hC8, 8'hCA,
        8'h88, 8'h24, 8'h28, 8'h40, 8'h00, 8'h38, 8'h18, 8'hF8, 8'hD8, 8'h78,
        8'h58, 8'hB8, 8'hAA, 8'hA8, 8'h8A, 8'h98, 8'hBA, 8'h9A};

    accu_alu u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .opcode(opcode), .operand(operand),
        .acc_q(acc_q), .x_q(x_q), .y_q(y_q), .status_q(status_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] zn(input logic [7:0] p, input logic [7:0] v);
        logic [7:0] r = p;
        r[1] = (v == 8'h00);
        r[7] = v[7];
        return r;
    endfunction

    function automatic logic [7:0] cmpf(input logic [7:0] p, input logic [7:0] r,
                                        input logic [7:0] m);
        logic [7:0] q = zn(p, r - m);
        q[0] = (r >= m);
        return q;
    endfunction

    // reference model written from the requirements
    task automatic model(input logic [7:0] op, input logic [7:0] m);
        logic [8:0] s;
        logic [4:0] lo;
        logic [5:0] hi;
        logic [7:0] r;
        case (op)
            8'hA9: begin ma = m; mp = zn(mp, ma); end
            8'hA2: begin mx = m; mp = zn(mp, mx); end
            8'hA0: begin my = m; mp = zn(mp, my); end
            8'h69: begin
                s = {1'b0, ma} + {1'b0, m} + {8'h00, mp[0]};
                mp[6] = (ma[7] == m[7]) && (s[7] != ma[7]);
                if (mp[3]) begin
                    lo = {1'b0, ma[3:0]} + {1'b0, m[3:0]} + {4'h0, mp[0]};
                    if (lo > 9) lo = lo + 6;
                    hi = {2'b00, ma[7:4]} + {2'b00, m[7:4]} + {5'h00, lo[4]};
                    if (hi > 9) hi = hi + 6;
                    r = {hi[3:0], lo[3:0]};
                    mp[0] = (hi > 15);
                end else begin
                    r = s[7:0];
                    mp[0] = s[8];
                end
                ma = r; mp = zn(mp, r);
            end
            8'hE9: begin
                s = {1'b0, ma} - {1'b0, m} - {8'h00, ~mp[0]};
                mp[6] = (ma[7] != m[7]) && (s[7] != ma[7]);
                mp[0] = ~s[8];
                ma = s[7:0]; mp = zn(mp, ma);
            end
            8'h29: begin ma = ma & m; mp = zn(mp, ma); end
            8'h09: begin ma = ma | m; mp = zn(mp, ma); end
            8'h49: begin ma = ma ^ m; mp = zn(mp, ma); end
            8'h0E: begin {mp[0], ma} = {m, 1'b0}; mp = zn(mp, ma); end
            8'h0A: begin {mp[0], ma} = {ma, 1'b0}; mp = zn(mp, ma); end
            8'h2E: begin {mp[0], ma} = {m, mp[0]}; mp = zn(mp, ma); end
            8'h6E: begin {ma, mp[0]} = {mp[0], m}; mp = zn(mp, ma); end
            8'hC9: mp = cmpf(mp, ma, m);
            8'hE0: mp = cmpf(mp, mx, m);
            8'hC0: mp = cmpf(mp, my, m);
            8'hE6: begin ma = m + 8'd1; mp = zn(mp, ma); end
            8'hC6: begin ma = m - 8'd1; mp = zn(mp, ma); end
            8'hE8: begin mx = mx + 8'd1; mp = zn(mp, mx); end
            8'hC8: begin my = my + 8'd1; mp = zn(mp, my); end
            8'hCA: begin mx = mx - 8'd1; mp = zn(mp, mx); end
            8'h88: begin my = my - 8'd1; mp = zn(mp, my); end
            8'h24: begin mp[1] = ((ma & m) == 0); mp[6] = m[6]; mp[7] = m[7]; end
            8'h28, 8'h40: mp = m | 8'h20;
            8'h00: mp[4] = 1'b1;
            8'h38: mp[0] = 1'b1;
            8'h18: mp[0] = 1'b0;
            8'hF8: mp[3] = 1'b1;
            8'hD8: mp[3] = 1'b0;
            8'h78: mp[2] = 1'b1;
            8'h58: mp[2] = 1'b0;
            8'hB8: mp[6] = 1'b0;
            8'hAA: begin mx = ma; mp = zn(mp, mx); end
            8'hA8: begin my = ma; mp = zn(mp, my); end
            8'h8A: begin ma = mx; mp = zn(mp, ma); end
            8'h98: begin ma = my; mp = zn(mp, ma); end
            8'hBA: begin mx = m; mp = zn(mp, mx); end
            8'h9A: ma = mx;
            default: ;
        endcase
    endtask

    task automatic compare(input string req);
        n_checks++;
        if (acc_q !== ma || x_q !== mx || y_q !== my || status_q !== mp) begin
            n_errors++;
            $display("FAIL %s op=%02h opd=%02h: got A=%02h X=%02h Y=%02h P=%02h expected A=%02h X=%02h Y=%02h P=%02h",
                     req, opcode, operand, acc_q, x_q, y_q, status_q, ma, mx, my, mp);
        end
    endtask

    // present at negedge, edge executes, sample at the next negedge
    task automatic run(input logic [7:0] op, input logic [7:0] m, input string req);
        opcode = op; operand = m; en = 1'b1;
        @(negedge clk);
        model(op, m);
        compare(req);
    endtask

    task automatic idle(input logic [7:0] op, input logic [7:0] m, input string req);
        opcode = op; operand = m; en = 1'b0;
        @(negedge clk);
        compare(req);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd2024));
        ma = 8'h00; mx = 8'h00; my = 8'h00; mp = 8'h22;
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");

        run(8'hA9, 8'h00, "R3 load A zero");
        run(8'hA9, 8'h80, "R3 load A negative");
        run(8'hA2, 8'h7F, "R3 load X");
        run(8'hA0, 8'h00, "R3 load Y zero");

        run(8'h18, 8'h00, "R13 clear C");
        run(8'hA9, 8'h7F, "R3");
        run(8'h69, 8'h01, "R4 signed overflow");
        run(8'hA9, 8'hFF, "R3");
        run(8'h69, 8'h01, "R4 carry out zero result");
        run(8'h69, 8'hFF, "R4 carry in");

        run(8'hF8, 8'h00, "R13 set D");
        run(8'h18, 8'h00, "R13");
        run(8'hA9, 8'h19, "R3");
        run(8'h69, 8'h28, "R5 decimal 19+28");
        run(8'hA9, 8'h99, "R3");
        run(8'h69, 8'h01, "R5 decimal wrap to 00");
        run(8'h69, 8'h09, "R5 decimal with carry in");
        run(8'h38, 8'h00, "R13 set C");
        run(8'hA9, 8'h50, "R3");
        run(8'hE9, 8'h20, "R6 subtract ignores D");
        run(8'hD8, 8'h00, "R13 clear D");

        run(8'h38, 8'h00, "R13");
        run(8'hA9, 8'h50, "R3");
        run(8'hE9, 8'hB0, "R6 overflow");
        run(8'hE9, 8'h00, "R6 borrow in");
        run(8'hA9, 8'h00, "R3");
        run(8'hE9, 8'h01, "R6 borrow out");

        run(8'hA9, 8'hF0, "R3");
        run(8'h29, 8'h3C, "R7 and");
        run(8'h09, 8'h81, "R7 or");
        run(8'h49, 8'hB1, "R7 xor to zero");

        run(8'h0E, 8'h81, "R8 shift mem");
        run(8'h2E, 8'h40, "R8 rotate left with C");
        run(8'h6E, 8'h01, "R8 rotate right");
        run(8'h6E, 8'h00, "R8 rotate right carry in");
        run(8'h0A, 8'h00, "R8 shift A");

        run(8'hA9, 8'h42, "R3");
        run(8'hC9, 8'h42, "R9 compare equal");
        run(8'hC9, 8'h43, "R9 compare less");
        run(8'hE0, 8'h7F, "R9 compare X");
        run(8'hC0, 8'h01, "R9 compare Y");

        run(8'hE6, 8'hFF, "R10 inc mem wrap");
        run(8'hC6, 8'h00, "R10 dec mem wrap");
        run(8'hA2, 8'hFF, "R3");
        run(8'hE8, 8'h00, "R10 inc X wrap");
        run(8'h88, 8'h00, "R10 dec Y wrap");
        run(8'hC8, 8'h00, "R10 inc Y");
        run(8'hCA, 8'h00, "R10 dec X");

        run(8'hA9, 8'h3F, "R3");
        run(8'h24, 8'hC0, "R11 bit zero with N V");
        run(8'h24, 8'h01, "R11 bit nonzero");

        run(8'hAA, 8'h00, "R12 A to X");
        run(8'hA8, 8'h00, "R12 A to Y");
        run(8'hBA, 8'h80, "R12 operand to X");
        run(8'h8A, 8'h00, "R12 X to A");
        run(8'hA0, 8'h00, "R3");
        run(8'h98, 8'h00, "R12 Y to A");
        run(8'hBA, 8'h91, "R12");
        run(8'h9A, 8'h00, "R12 X to stack keeps flags");

        run(8'h28, 8'hFF, "R13 pull all ones");
        run(8'h40, 8'h00, "R13 return forces bit 5");
        run(8'h00, 8'h00, "R13 break sets B");
        run(8'h78, 8'h00, "R13 set I");
        run(8'h58, 8'h00, "R13 clear I");
        run(8'h28, 8'h40, "R13");
        run(8'hB8, 8'h00, "R13 clear V");

        idle(8'hA9, 8'h55, "R2 disabled load");
        idle(8'h28, 8'hFF, "R2 disabled pull");
        run(8'h02, 8'hFF, "R14 undefined opcode");
        run(8'hEA, 8'h00, "R14 nop");
        run(8'h8D, 8'h12, "R14 store");
        run(8'h4C, 8'h34, "R14 jump");
        run(8'hF0, 8'h00, "R14 branch");

        for (int i = 0; i < 6000; i++) begin
            logic [7:0] op;
            if ($urandom_range(0, 3) != 0)
                op = SUPPORTED[$urandom_range(0, 37)];
            else
                op = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 15) == 0)
                idle(op, 8'($urandom_range(0, 255)), "R2 random idle");
            else
                run(op, 8'($urandom_range(0, 255)), "random mix");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule